// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the scan timing for a directly attached LCD panel. A horizontal pixel counter and a vertical line counter advance on a pixel-rate enable. From them the block derives horizontal sync, vertical sync, a data-enable window and the zero-based coordinate of the current active pixel. It also raises two single-cycle markers. The early-start marker tells the upstream pixel engine to begin fetching a fixed number of lines before the first visible line. The line interrupt marks a programmable point in vertical blanking.

Timing comes from four 32-bit configuration words and three control bits. Each word packs two 16-bit fields, stored minus one or, for the vertical total, in half-line units. The words are captured into a shadow copy only when a frame starts, so software may rewrite them at any time without producing a torn frame. The pad output-enable is high only while both enables are set and the scan has started. With the output-enable low, the panel pins are to be left at high impedance.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is low, and in the cycle after it, every output is 0.
- R2: `pad_oe` goes high only after a `pix_en` cycle seen while both `glb_en` and `chan_en` are high. Clearing either enable drops `pad_oe`, `hsync`, `vsync`, `de`, the coordinates and the markers to 0 one clock later, and the scan restarts at pixel 0 of line 0.
- R3: The line length is `cfg_horiz[31:16]`+1 pixels. On each enabled `pix_en` cycle, pixel 0 of line 0 follows the first enabled cycle, and the pixel index wraps after the last pixel. Horizontal sync is active for pixels 0 to `cfg_sync[31:16]`, so a field value of 0 gives a one-pixel pulse.
- R4: `de` is high when the pixel index lies in [HBP, HBP+W) and the line index lies in [VBP, VBP+H). Here HBP is `cfg_horiz[15:0]`+1, W is `cfg_active[31:16]`+1, VBP is `cfg_vert[15:0]`+1 and H is `cfg_active[15:0]`+1. `px_x`/`px_y` equal pixel−HBP and line−VBP while `de` is high, and 0 otherwise.
- R5: In progressive mode a frame has `cfg_vert[31:16]`/2 lines, rounded down. Vertical sync is active for lines 0 to `cfg_sync[15:0]`.
- R6: `cfg_hs_high`=1 makes `hsync` active-high and 0 makes it active-low. `cfg_vs_high` does the same for `vsync`.
- R7: Let the blanking B be the lines per frame (or per field) minus H. The start delay SD is 30 when B ≥ 32 and B−2 otherwise. `early_start` pulses for one clock at pixel 0 of line (VBP−SD), taken modulo the frame length.
- R8: `line_irq` pulses for one clock at pixel 0 of line SD+2.
- R9: The configuration words and mode bits are sampled only when the scan starts and when it wraps into a new frame (field 0). A change in mid-frame has no effect before that point.
- R10: With `cfg_interlace`=1, the frame of N = `cfg_vert[31:16]`/2 lines is split into fields. Field 0 has (N+1)/2 lines and field 1 has N/2 lines. The fields alternate, `field_o` shows the current field, and the line index restarts at 0 in each field.
- R11: A cycle with `pix_en` low leaves the position and all level outputs unchanged and clears both markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate advance enable |
| glb_en | input | 1 | Global enable |
| chan_en | input | 1 | Channel enable |
| cfg_active | input | 32 | [31:16] width−1, [15:0] height−1 |
| cfg_horiz | input | 32 | [31:16] line total−1, [15:0] back porch−1 (from sync start) |
| cfg_vert | input | 32 | [31:16] frame total in half lines, [15:0] back porch−1 |
| cfg_sync | input | 32 | [31:16] hsync width−1, [15:0] vsync width−1 |
| cfg_interlace | input | 1 | Field mode |
| cfg_hs_high | input | 1 | Horizontal sync polarity, 1 = active-high |
| cfg_vs_high | input | 1 | Vertical sync polarity, 1 = active-high |
| pad_oe | output | 1 | Panel pins driven when high, high impedance when low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | 16 | Active pixel column |
| px_y | output | 16 | Active line row |
| field_o | output | 1 | Current field |
| early_start | output | 1 | Early frame-start marker |
| line_irq | output | 1 | Line-match interrupt |

## Verification
The assertions assume a programming the hardware can sensibly scan. The line total is at least 2, and the back porch plus width fits in the line. The frame or field length exceeds H by at least 2 lines, and the back porch plus height fits in the frame. Under these assumptions the counters stay below their totals, and the one-clock markers cannot repeat on back-to-back cycles. Every bench configuration respects these bounds, including its mid-frame rewrite. The bench also covers both interlaced field lengths, the capped (B ≥ 32) start delay, and an early-start line that wraps around the end of the frame.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
    // register word width and the width of each packed field
    localparam int unsigned RW = 32;
    localparam int unsigned FW = RW / 2;
    // start-delay rule constants
    localparam int unsigned SD_CAP  = 30;
    localparam int unsigned SD_THR  = 32;
    localparam int unsigned SD_SUB  = 2;
    localparam int unsigned IRQ_OFS = 2;

    typedef struct packed {
        logic [RW-1:0] act;
        logic [RW-1:0] hor;
        logic [RW-1:0] ver;
        logic [RW-1:0] syn;
        logic          il;
        logic          hp;
        logic          vp;
    } cfg_t;

    typedef struct packed {
        logic [FW-1:0] wid;
        logic [FW-1:0] hgt;
        logic [FW-1:0] htot;
        logic [FW-1:0] hbp;
        logic [FW-1:0] hsw;
        logic [FW-1:0] vsw;
        logic [FW-1:0] vbp;
        logic [FW-1:0] lines;
        logic [FW-1:0] sdel;
        logic [FW-1:0] early_ln;
        logic [FW-1:0] irq_ln;
        logic          il;
        logic          hp;
        logic          vp;
    } tim_t;
endpackage

// File: rtl/lcd_tg_decode.sv
// Turns the packed minus-one / half-line words into plain counts,
// and derives the start delay and the two marker lines.
module lcd_tg_decode
    import lcd_tg_pkg::*;
(
    input  cfg_t cfg,
    input  logic field,
    output tim_t tim
);
    localparam logic [FW:0] THR  = (FW+1)'(SD_THR);
    localparam logic [FW:0] CAP  = (FW+1)'(SD_CAP);
    localparam logic [FW:0] SUB  = (FW+1)'(SD_SUB);
    localparam logic [FW-1:0] IRQ = FW'(IRQ_OFS);

    logic [FW:0] n_lines, f_lines, hgt_x, vbp_x, blank, sd, early;
    logic        unused_hi;

    always_comb begin
        n_lines = {1'b0, cfg.ver[RW-1:FW]} >> 1;
        if (cfg.il)
            f_lines = field ? (n_lines >> 1) : ((n_lines + 1'b1) >> 1);
        else
            f_lines = n_lines;
        hgt_x = {1'b0, cfg.act[FW-1:0]} + 1'b1;
        vbp_x = {1'b0, cfg.ver[FW-1:0]} + 1'b1;
        blank = (f_lines > hgt_x) ? (f_lines - hgt_x) : '0;
        if (blank >= THR)       sd = CAP;
        else if (blank >= SUB)  sd = blank - SUB;
        else                    sd = '0;
        // fetch lead wraps to the end of the previous frame when needed
        early = (vbp_x >= sd) ? (vbp_x - sd) : (vbp_x + f_lines - sd);

        tim          = '0;
        tim.wid      = cfg.act[RW-1:FW] + 1'b1;
        tim.hgt      = hgt_x[FW-1:0];
        tim.htot     = cfg.hor[RW-1:FW] + 1'b1;
        tim.hbp      = cfg.hor[FW-1:0] + 1'b1;
        tim.hsw      = cfg.syn[RW-1:FW] + 1'b1;
        tim.vsw      = cfg.syn[FW-1:0] + 1'b1;
        tim.vbp      = vbp_x[FW-1:0];
        tim.lines    = f_lines[FW-1:0];
        tim.sdel     = sd[FW-1:0];
        tim.early_ln = early[FW-1:0];
        tim.irq_ln   = sd[FW-1:0] + IRQ;
        tim.il       = cfg.il;
        tim.hp       = cfg.hp;
        tim.vp       = cfg.vp;
    end

    assign unused_hi = ^{hgt_x[FW], vbp_x[FW], early[FW]};
endmodule

// File: rtl/lcd_tg_shadow.sv
// Holds the configuration that governs the frame in progress.
module lcd_tg_shadow
    import lcd_tg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  cfg_t cfg_in,
    input  logic load,
    output cfg_t cfg_q,
    output cfg_t cfg_d
);
    cfg_t sh_d, sh_q;

    always_comb begin
        sh_d = load ? cfg_in : sh_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign cfg_q = sh_q;
    assign cfg_d = sh_d;
endmodule

// File: rtl/lcd_tg_scan.sv
// Pixel / line / field counters.
module lcd_tg_scan
    import lcd_tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pix_en,
    input  logic [FW-1:0] htot,
    input  logic [FW-1:0] lines,
    input  logic          il,
    output logic [FW-1:0] hc_d,
    output logic [FW-1:0] vc_d,
    output logic          fld_d,
    output logic          fld_q,
    output logic          run_d,
    output logic          adv,
    output logic          load
);
    typedef struct packed {
        logic [FW-1:0] hc;
        logic [FW-1:0] vc;
        logic          fld;
        logic          run;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        adv  = 1'b0;
        load = 1'b0;
        if (!en) begin
            s_d = '0;
        end else if (pix_en) begin
            adv = 1'b1;
            if (!s_q.run) begin
                s_d  = '0;
                s_d.run = 1'b1;
                load = 1'b1;
            end else if (s_q.hc >= htot - 1'b1) begin
                s_d.hc = '0;
                if (s_q.vc >= lines - 1'b1) begin
                    s_d.vc  = '0;
                    s_d.fld = il ? ~s_q.fld : 1'b0;
                    load    = ~s_d.fld;
                end else begin
                    s_d.vc = s_q.vc + 1'b1;
                end
            end else begin
                s_d.hc = s_q.hc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hc_d  = s_d.hc;
    assign vc_d  = s_d.vc;
    assign fld_d = s_d.fld;
    assign fld_q = s_q.fld;
    assign run_d = s_d.run;

    assert_hc_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.hc < htot));
    assert_vc_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.vc < lines));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          glb_en,
    input  logic          chan_en,
    input  logic [RW-1:0] cfg_active,
    input  logic [RW-1:0] cfg_horiz,
    input  logic [RW-1:0] cfg_vert,
    input  logic [RW-1:0] cfg_sync,
    input  logic          cfg_interlace,
    input  logic          cfg_hs_high,
    input  logic          cfg_vs_high,
    output logic          pad_oe,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [FW-1:0] px_x,
    output logic [FW-1:0] px_y,
    output logic          field_o,
    output logic          early_start,
    output logic          line_irq
);
    typedef struct packed {
        logic          oe;
        logic          hs;
        logic          vs;
        logic          de;
        logic [FW-1:0] x;
        logic [FW-1:0] y;
        logic          fld;
        logic          early;
        logic          irq;
    } out_t;

    logic          en;
    cfg_t          cfg_in, cfg_q, cfg_d;
    tim_t          tc, tn;
    logic [FW-1:0] hc_d, vc_d;
    logic          fld_d, fld_q, run_d, adv, load;
    logic          hs_on, vs_on, h_in, v_in;
    logic [FW:0]   h_end, v_end;
    logic          unused_bits;
    out_t          o_d, o_q;

    assign en     = glb_en & chan_en;
    assign cfg_in = '{act: cfg_active, hor: cfg_horiz, ver: cfg_vert, syn: cfg_sync,
                      il: cfg_interlace, hp: cfg_hs_high, vp: cfg_vs_high};

    lcd_tg_shadow u_shadow (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .load(load),
        .cfg_q(cfg_q), .cfg_d(cfg_d)
    );

    // timing of the frame in progress steers the counters
    lcd_tg_decode u_dec_now  (.cfg(cfg_q), .field(fld_q), .tim(tc));
    // timing of the position being entered steers the outputs
    lcd_tg_decode u_dec_next (.cfg(cfg_d), .field(fld_d), .tim(tn));

    lcd_tg_scan u_scan (
        .clk(clk), .rst_n(rst_n), .en(en), .pix_en(pix_en),
        .htot(tc.htot), .lines(tc.lines), .il(tc.il),
        .hc_d(hc_d), .vc_d(vc_d), .fld_d(fld_d), .fld_q(fld_q),
        .run_d(run_d), .adv(adv), .load(load)
    );

    always_comb begin
        hs_on = hc_d < tn.hsw;
        vs_on = vc_d < tn.vsw;
        h_end = {1'b0, tn.hbp} + {1'b0, tn.wid};
        v_end = {1'b0, tn.vbp} + {1'b0, tn.hgt};
        h_in  = (hc_d >= tn.hbp) && ({1'b0, hc_d} < h_end);
        v_in  = (vc_d >= tn.vbp) && ({1'b0, vc_d} < v_end);

        o_d       = o_q;
        o_d.early = 1'b0;
        o_d.irq   = 1'b0;
        if (!en) begin
            o_d = '0;
        end else if (adv) begin
            o_d.hs    = tn.hp ? hs_on : ~hs_on;
            o_d.vs    = tn.vp ? vs_on : ~vs_on;
            o_d.de    = h_in & v_in;
            o_d.x     = (h_in & v_in) ? (hc_d - tn.hbp) : '0;
            o_d.y     = (h_in & v_in) ? (vc_d - tn.vbp) : '0;
            o_d.fld   = fld_d;
            o_d.early = (hc_d == '0) && (vc_d == tn.early_ln);
            o_d.irq   = (hc_d == '0) && (vc_d == tn.irq_ln);
        end
        o_d.oe = run_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign pad_oe      = o_q.oe;
    assign hsync       = o_q.hs;
    assign vsync       = o_q.vs;
    assign de          = o_q.de;
    assign px_x        = o_q.x;
    assign px_y        = o_q.y;
    assign field_o     = o_q.fld;
    assign early_start = o_q.early;
    assign line_irq    = o_q.irq;
    assign unused_bits = ^{tc, tn};

    assert_de_needs_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> pad_oe);
    assert_x_in_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (px_x < tc.wid));
    assert_early_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        early_start |=> !early_start);
    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |=> !line_irq);
    assert_hold_no_pix_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && en && !pix_en) |=>
            ($stable(px_x) && $stable(px_y) && $stable(de) && $stable(hsync) && $stable(vsync)));
endmodule

// File: tb/lcd_timing_gen_test.sv
`timescale 1ns/1ps
module lcd_timing_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0, glb_en = 1'b0, chan_en = 1'b0;
    logic [31:0] c_act = '0, c_hor = '0, c_ver = '0, c_syn = '0;
    logic        c_il = 1'b0, c_hp = 1'b0, c_vp = 1'b0;
    logic        pad_oe, hsync, vsync, de, field_o, early_start, line_irq;
    logic [15:0] px_x, px_y;

    always #10 clk = ~clk;

    lcd_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .glb_en(glb_en), .chan_en(chan_en),
        .cfg_active(c_act), .cfg_horiz(c_hor), .cfg_vert(c_ver), .cfg_sync(c_syn),
        .cfg_interlace(c_il), .cfg_hs_high(c_hp), .cfg_vs_high(c_vp),
        .pad_oe(pad_oe), .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y),
        .field_o(field_o), .early_start(early_start), .line_irq(line_irq)
    );

    typedef struct packed {
        logic [31:0] act, hor, ver, syn;
        logic        il, hp, vp;
        logic [1:0]  div;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h0003_0002, 32'h0009_0002, 32'h0010_0001, 32'h0001_0000, 1'b0, 1'b0, 1'b0, 2'd1, 16'd200},
        '{32'h0001_0001, 32'h0005_0001, 32'h0050_0021, 32'h0000_0001, 1'b0, 1'b1, 1'b1, 2'd2, 16'd1100},
        '{32'h0003_0001, 32'h0007_0002, 32'h0012_0001, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 2'd1, 16'd300},
        '{32'h0002_0003, 32'h0004_0000, 32'h000F_0000, 32'h0001_0002, 1'b0, 1'b0, 1'b1, 2'd1, 16'd100}
    };

    int checks = 0, failures = 0;
    int mism [7];
    logic [63:0] fa [7], fe [7];
    string tags [7] = '{"R2 pad enable", "R3 R6 hsync", "R5 R6 vsync", "R4 de and coordinate",
                        "R7 early start", "R8 line irq", "R10 field"};

    // reference model state
    int m_run = 0, m_h = 0, m_v = 0, m_f = 0;
    logic [31:0] s_act = '0, s_hor = '0, s_ver = '0, s_syn = '0;
    logic s_il = 0, s_hp = 0, s_vp = 0;
    logic e_oe = 0, e_hs = 0, e_vs = 0, e_de = 0, e_f = 0, e_early = 0, e_irq = 0;
    int e_x = 0, e_y = 0;

    function automatic int fl(int f);
        int n = int'(s_ver[31:16]) / 2;
        if (!s_il) return n;
        return (f != 0) ? n / 2 : (n + 1) / 2;
    endfunction

    function automatic int sdl(int f);
        int b = fl(f) - (int'(s_act[15:0]) + 1);
        if (b < 0) b = 0;
        if (b >= 32) return 30;
        return (b >= 2) ? b - 2 : 0;
    endfunction

    task automatic model_step();
        int ht, hbp, w, vbp, h, hsw, vsw, sd, el;
        if (!rst_n || !(glb_en && chan_en)) begin
            m_run = 0; m_h = 0; m_v = 0; m_f = 0;
            e_oe = 0; e_hs = 0; e_vs = 0; e_de = 0; e_x = 0; e_y = 0; e_f = 0; e_early = 0; e_irq = 0;
            if (!rst_n) begin s_act = '0; s_hor = '0; s_ver = '0; s_syn = '0; s_il = 0; s_hp = 0; s_vp = 0; end
            return;
        end
        if (!pix_en) begin e_early = 0; e_irq = 0; return; end
        if (m_run == 0) begin
            m_run = 1; m_h = 0; m_v = 0; m_f = 0;
            s_act = c_act; s_hor = c_hor; s_ver = c_ver; s_syn = c_syn; s_il = c_il; s_hp = c_hp; s_vp = c_vp;
        end else begin
            ht = int'(s_hor[31:16]) + 1;
            if (m_h + 1 < ht) m_h++;
            else begin
                m_h = 0;
                if (m_v + 1 < fl(m_f)) m_v++;
                else begin
                    m_v = 0;
                    m_f = s_il ? 1 - m_f : 0;
                    if (m_f == 0) begin
                        s_act = c_act; s_hor = c_hor; s_ver = c_ver; s_syn = c_syn;
                        s_il = c_il; s_hp = c_hp; s_vp = c_vp;
                    end
                end
            end
        end
        hbp = int'(s_hor[15:0]) + 1;  w = int'(s_act[31:16]) + 1;
        vbp = int'(s_ver[15:0]) + 1;  h = int'(s_act[15:0]) + 1;
        hsw = int'(s_syn[31:16]) + 1; vsw = int'(s_syn[15:0]) + 1;
        sd  = sdl(m_f);
        el  = (vbp >= sd) ? vbp - sd : vbp + fl(m_f) - sd;
        e_oe = 1;
        e_hs = s_hp ? (m_h < hsw) : !(m_h < hsw);
        e_vs = s_vp ? (m_v < vsw) : !(m_v < vsw);
        e_de = (m_h >= hbp) && (m_h < hbp + w) && (m_v >= vbp) && (m_v < vbp + h);
        e_x  = e_de ? m_h - hbp : 0;
        e_y  = e_de ? m_v - vbp : 0;
        e_f  = logic'(m_f);
        e_early = (m_h == 0) && (m_v == el);
        e_irq   = (m_h == 0) && (m_v == sd + 2);
    endtask

    task automatic cmp(int k, logic [63:0] a, logic [63:0] e);
        if (a !== e) begin
            if (mism[k] == 0) begin fa[k] = a; fe[k] = e; end
            mism[k]++;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmp(0, 64'(pad_oe), 64'(e_oe));
        cmp(1, 64'(hsync), 64'(e_hs));
        cmp(2, 64'(vsync), 64'(e_vs));
        cmp(3, {31'd0, de, px_x, px_y}, {31'd0, e_de, 16'(e_x), 16'(e_y)});
        cmp(4, 64'(early_start), 64'(e_early));
        cmp(5, 64'(line_irq), 64'(e_irq));
        cmp(6, 64'(field_o), 64'(e_f));
    endtask

    task automatic finish_phase(string ph);
        for (int k = 0; k < 7; k++) begin
            checks++;
            if (mism[k] != 0) begin
                failures++;
                $display("FAIL %s %s: %0d mismatches, first actual=%h expected=%h",
                         ph, tags[k], mism[k], fa[k], fe[k]);
            end
            mism[k] = 0;
        end
    endtask

    task automatic direct(string req, logic [63:0] a, logic [63:0] e);
        checks++;
        if (a !== e) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic apply(vec_t v);
        c_act = v.act; c_hor = v.hor; c_ver = v.ver; c_syn = v.syn;
        c_il = v.il; c_hp = v.hp; c_vp = v.vp;
    endtask

    initial begin
        logic [7:0] lfsr;
        for (int k = 0; k < 7; k++) mism[k] = 0;
        // R1: reset state
        repeat (3) tick();
        direct("R1 outputs during reset",
               {55'd0, pad_oe, hsync, vsync, de, field_o, early_start, line_irq, |px_x, |px_y}, 64'd0);
        rst_n = 1'b1;
        tick();
        direct("R1 outputs after reset", {62'd0, pad_oe, de}, 64'd0);
        finish_phase("R1 reset");

        // table walk: R3 R4 R5 R6 R7 R8 R10 under several programmings
        for (int i = 0; i < 4; i++) begin
            apply(VECS[i]);
            glb_en = 1'b1; chan_en = 1'b1;
            for (int k = 0; k < int'(VECS[i].cyc); k++) begin
                pix_en = (k % int'(VECS[i].div)) == 0;
                tick();
            end
            finish_phase($sformatf("vector %0d", i));
            if (i % 2 == 1) glb_en = 1'b0; else chan_en = 1'b0;
            pix_en = 1'b1;
            repeat (3) tick();
        end

        // R9: rewrite configuration in mid-frame
        apply(VECS[0]); glb_en = 1'b1; chan_en = 1'b1; pix_en = 1'b1;
        repeat (35) tick();
        apply(VECS[3]);
        repeat (200) tick();
        finish_phase("R9 mid-frame rewrite");

        // R11: irregular pixel enable
        glb_en = 1'b0; tick();
        apply(VECS[2]); glb_en = 1'b1;
        lfsr = 8'hA5;
        for (int k = 0; k < 500; k++) begin
            pix_en = lfsr[0] | lfsr[3];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tick();
        end
        finish_phase("R11 irregular pix_en");

        // R2: enable gating, directed
        pix_en = 1'b1; chan_en = 1'b0; tick();
        direct("R2 channel off drops pins", {60'd0, pad_oe, hsync, vsync, de}, 64'd0);
        chan_en = 1'b1; glb_en = 1'b0; tick();
        direct("R2 global off keeps pads off", 64'(pad_oe), 64'd0);
        glb_en = 1'b1; pix_en = 1'b0; tick();
        direct("R2 no drive before first pix_en", 64'(pad_oe), 64'd0);
        pix_en = 1'b1; tick();
        direct("R2 drive after first pix_en", {62'd0, pad_oe, field_o}, 64'd2);
        finish_phase("R2 enable gating");

        // R1: reset in mid-run
        rst_n = 1'b0; tick();
        direct("R1 mid-run reset", {59'd0, pad_oe, de, early_start, line_irq, field_o}, 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule